// File: doc/BRIEF.md
# Accumulator processor control sequencer

This block is the control sequencer of a small accumulator processor with an 8-bit address space over a 256-word, 16-bit-wide program and data memory. It steps every instruction through a fetch state, a decode state and one or two execute states. It keeps the program counter, the instruction register, an index counter for data addressing and a save register for subroutine return. It drives the memory read and write strobes, the address bus, the store data, the ALU operation select, the accumulator and B-register load strobes and the B-register increment and decrement strobes. The ALU and the registers it steers sit outside the block.

An external reset passes through a short synchronizer and becomes the internal reset. While the internal reset is high, a host loader owns the memory bus and can write a program into memory. The sequencer takes the bus only after the internal reset falls. From then on it fetches from address 0. An instruction word carries its opcode in bits 7:0 and an 8-bit operand (index value or branch offset) in bits 15:8.

Top module: `acc_seq_ctrl`

## Requirements
- R1: The internal reset rises at once when `rst_ext` rises. After `rst_ext` falls, it stays high through the first rising clock edge and drops on the second.
- R2: While the internal reset is high, `mem_addr`, `mem_wdata` and `mem_wr` follow `ldr_addr`, `ldr_wdata` and `ldr_wr`. In that time `mem_rd`, `ld_a`, `ld_b`, `b_inc` and `b_dec` are 0 and `alu_op` is 0.
- R3: Each instruction starts with a one-cycle read at the program counter, which is 0 after reset and advances by one on each fetch. The opcode is bits 7:0 of the word read.
- R4: Opcode 17h (load B immediate) reads the next word in a second one-cycle read and advances the program counter again. In the cycle after that read it pulses `ld_b` with `alu_op` = 00h (pass memory data).
- R5: Register operations each pulse their strobes for one execute cycle. 1Dh gives `ld_a` with `alu_op` 01h (pass B). 1Bh gives `ld_b` with 0Ah (controlled-NOT pair). 20h gives `ld_a` and `ld_b` with 0Bh (Fredkin triple). 0Ch gives `b_inc` and 0Dh gives `b_dec`, both with `alu_op` 00h.
- R6: The index counter starts at 0. Opcode 30h loads it from bits 15:8, 31h increments it and 32h decrements it. Opcode 33h reads memory at the index, then pulses `ld_a` with `alu_op` 00h. Opcode 34h writes `acc_in` to memory at the index for one cycle.
- R7: Opcode 40h (branch if greater) samples `flag_gt` in its execute cycle. When it is 1, the program counter becomes the address after the branch plus the signed offset in bits 15:8, modulo 256. When it is 0, execution falls through.
- R8: Opcode 41h saves the address after itself in the save register and branches relative, like a taken 40h. Opcode 42h reloads the program counter from the save register.
- R9: Opcode 07h halts the sequencer: no read, write or strobe follows until reset. Opcode 08h and unassigned opcodes cause no activity beyond their own fetch.
- R10: `mem_rd` and `mem_wr` are never high in the same cycle, and `mem_rd` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_ext | input | 1 | Asynchronous external reset, active high |
| ldr_addr | input | 8 | Host loader address, driven onto the bus during reset |
| ldr_wdata | input | 16 | Host loader write data |
| ldr_wr | input | 1 | Host loader write strobe |
| mem_rdata | input | 16 | Memory read data, valid the cycle after a read strobe |
| flag_gt | input | 1 | Greater flag from the datapath |
| acc_in | input | 16 | Accumulator value used as store data |
| mem_addr | output | 8 | Memory address bus |
| mem_wdata | output | 16 | Memory write data |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| alu_op | output | 5 | ALU operation select |
| ld_a | output | 1 | Accumulator load strobe |
| ld_b | output | 1 | Register B load strobe |
| b_inc | output | 1 | Register B increment strobe |
| b_dec | output | 1 | Register B decrement strobe |

## Verification
Several properties are checked on every clock cycle. Reads and writes never overlap and a read never lasts two cycles. The halt state never lets go. The program counter steps by one on a plain increment, stands still on a branch that is not taken, and lands exactly on the saved value on a return. The synchronizer stages shift in order. The bench's scenarios cover what depends on program content. These are the exact order of bus and strobe events for each opcode, the addresses of the second reads and the index-addressed accesses, branch targets both taken and skipped (trap words catch a wrong path), the call and return round trip, the loader's ownership of the bus, and the two-edge reset release.

// File: rtl/seq_pkg.sv
`timescale 1ns/1ps
package seq_pkg;
    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_EXEC2,
        ST_HALT
    } seq_state_e;

    localparam int ALU_W = 5;
    localparam int OPC_W = 8;

    localparam logic [OPC_W-1:0] OPC_HLT  = 8'h07;
    localparam logic [OPC_W-1:0] OPC_NOP  = 8'h08;
    localparam logic [OPC_W-1:0] OPC_INCB = 8'h0C;
    localparam logic [OPC_W-1:0] OPC_DECB = 8'h0D;
    localparam logic [OPC_W-1:0] OPC_LDB  = 8'h17;
    localparam logic [OPC_W-1:0] OPC_CNB  = 8'h1B;
    localparam logic [OPC_W-1:0] OPC_LAB  = 8'h1D;
    localparam logic [OPC_W-1:0] OPC_FGO  = 8'h20;
    localparam logic [OPC_W-1:0] OPC_LDX  = 8'h30;
    localparam logic [OPC_W-1:0] OPC_INX  = 8'h31;
    localparam logic [OPC_W-1:0] OPC_DEX  = 8'h32;
    localparam logic [OPC_W-1:0] OPC_LDA  = 8'h33;
    localparam logic [OPC_W-1:0] OPC_STA  = 8'h34;
    localparam logic [OPC_W-1:0] OPC_BGT  = 8'h40;
    localparam logic [OPC_W-1:0] OPC_CALL = 8'h41;
    localparam logic [OPC_W-1:0] OPC_RET  = 8'h42;

    localparam logic [ALU_W-1:0] ALU_PASS  = 5'h00;
    localparam logic [ALU_W-1:0] ALU_PASSB = 5'h01;
    localparam logic [ALU_W-1:0] ALU_CNB   = 5'h0A;
    localparam logic [ALU_W-1:0] ALU_FGO   = 5'h0B;
endpackage

// File: rtl/seq_rst_sync.sv
`timescale 1ns/1ps
module seq_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_ext,
    output logic rst_int
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], 1'b0};
    end

    always_ff @(posedge clk or posedge rst_ext) begin
        if (rst_ext) sh_q <= '1;
        else         sh_q <= sh_d;
    end

    assign rst_int = sh_q[LAST];

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_chk
            AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (rst_ext)
                !sh_q[g-1] |=> !sh_q[g]); // R1
        end
    endgenerate
endmodule

// File: rtl/seq_pc.sv
`timescale 1ns/1ps
module seq_pc #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          ld1,
    input  logic [AW-1:0] in1,
    input  logic          ld2,
    input  logic [AW-1:0] in2,
    output logic [AW-1:0] pc
);
    localparam logic [AW-1:0] STEP = AW'(1);

    logic [AW-1:0] pc_d, pc_q;
    logic [AW-1:0] sum;

    always_comb begin
        sum  = pc_q + STEP;
        pc_d = pc_q;
        if (ld2)      pc_d = in2;
        else if (ld1) pc_d = in1;
        else if (inc) pc_d = sum;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_d;
    end

    assign pc = pc_q;

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (inc && !ld1 && !ld2) |=> pc_q == $past(pc_q) + STEP); // R3
    AST_PC_RELOAD: assert property (@(posedge clk) disable iff (rst)
        ld2 |=> pc_q == $past(in2)); // R8
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!inc && !ld1 && !ld2) |=> $stable(pc_q)); // R7
endmodule

// File: rtl/seq_ctrl.sv
`timescale 1ns/1ps
module seq_ctrl
    import seq_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             flag_gt,
    input  logic [DW-1:0]    acc_in,
    output logic [AW-1:0]    p_addr,
    output logic [DW-1:0]    p_wdata,
    output logic             p_rd,
    output logic             p_wr,
    output logic [ALU_W-1:0] alu_op,
    output logic             ld_a,
    output logic             ld_b,
    output logic             b_inc,
    output logic             b_dec
);
    localparam int OFF_LSB = DW - AW;

    typedef struct packed {
        seq_state_e    st;
        logic [DW-1:0] ir;
        logic [AW-1:0] ix;
        logic [AW-1:0] sv;
    } ctl_s;

    ctl_s          c_d, c_q;
    logic [AW-1:0] pc_q;
    logic          pc_inc, pc_ld1, pc_ld2;
    logic [AW-1:0] br_tgt;
    logic [OPC_W-1:0] opc;
    logic [AW-1:0] off;

    assign opc    = c_q.ir[OPC_W-1:0];
    assign off    = c_q.ir[DW-1:OFF_LSB];
    assign br_tgt = pc_q + off;

    seq_pc #(.AW(AW)) i_pc (
        .clk (clk),
        .rst (rst),
        .inc (pc_inc),
        .ld1 (pc_ld1),
        .in1 (br_tgt),
        .ld2 (pc_ld2),
        .in2 (c_q.sv),
        .pc  (pc_q)
    );

    always_comb begin
        c_d     = c_q;
        p_addr  = pc_q;
        p_wdata = '0;
        p_rd    = 1'b0;
        p_wr    = 1'b0;
        alu_op  = ALU_PASS;
        ld_a    = 1'b0;
        ld_b    = 1'b0;
        b_inc   = 1'b0;
        b_dec   = 1'b0;
        pc_inc  = 1'b0;
        pc_ld1  = 1'b0;
        pc_ld2  = 1'b0;
        unique case (c_q.st)
            ST_FETCH: begin
                p_rd   = 1'b1;
                pc_inc = 1'b1;
                c_d.st = ST_DECODE;
            end
            ST_DECODE: begin
                c_d.ir = mem_rdata;
                c_d.st = ST_EXEC;
            end
            ST_EXEC: begin
                c_d.st = ST_FETCH;
                case (opc)
                    OPC_LDB: begin
                        p_rd   = 1'b1;
                        pc_inc = 1'b1;
                        c_d.st = ST_EXEC2;
                    end
                    OPC_LAB: begin
                        ld_a   = 1'b1;
                        alu_op = ALU_PASSB;
                    end
                    OPC_CNB: begin
                        ld_b   = 1'b1;
                        alu_op = ALU_CNB;
                    end
                    OPC_FGO: begin
                        ld_a   = 1'b1;
                        ld_b   = 1'b1;
                        alu_op = ALU_FGO;
                    end
                    OPC_INCB: b_inc = 1'b1;
                    OPC_DECB: b_dec = 1'b1;
                    OPC_LDX:  c_d.ix = off;
                    OPC_INX:  c_d.ix = c_q.ix + AW'(1);
                    OPC_DEX:  c_d.ix = c_q.ix - AW'(1);
                    OPC_LDA: begin
                        p_rd   = 1'b1;
                        p_addr = c_q.ix;
                        c_d.st = ST_EXEC2;
                    end
                    OPC_STA: begin
                        p_wr    = 1'b1;
                        p_addr  = c_q.ix;
                        p_wdata = acc_in;
                    end
                    OPC_BGT:  pc_ld1 = flag_gt;
                    OPC_CALL: begin
                        c_d.sv = pc_q;
                        pc_ld1 = 1'b1;
                    end
                    OPC_RET:  pc_ld2 = 1'b1;
                    OPC_HLT:  c_d.st = ST_HALT;
                    default: ;
                endcase
            end
            ST_EXEC2: begin
                c_d.st = ST_FETCH;
                case (opc)
                    OPC_LDB: ld_b = 1'b1;
                    OPC_LDA: ld_a = 1'b1;
                    default: ;
                endcase
            end
            ST_HALT: c_d.st = ST_HALT;
            default: c_d.st = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            c_q.st <= ST_FETCH;
            c_q.ir <= '0;
            c_q.ix <= '0;
            c_q.sv <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(p_rd && p_wr)); // R10
    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        p_rd |=> !p_rd); // R10
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (c_q.st == ST_HALT) |=> (c_q.st == ST_HALT && !p_rd && !p_wr && !ld_a && !ld_b)); // R9
    AST_PC_ONE_SRC: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pc_inc, pc_ld1, pc_ld2})); // R3
    AST_BR_SKIP: assert property (@(posedge clk) disable iff (rst)
        (c_q.st == ST_EXEC && opc == OPC_BGT && !flag_gt) |=> pc_q == $past(pc_q)); // R7
endmodule

// File: rtl/acc_seq_ctrl.sv
`timescale 1ns/1ps
module acc_seq_ctrl
    import seq_pkg::*;
#(
    parameter int AW          = 8,
    parameter int DW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_ext,
    input  logic [AW-1:0]    ldr_addr,
    input  logic [DW-1:0]    ldr_wdata,
    input  logic             ldr_wr,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             flag_gt,
    input  logic [DW-1:0]    acc_in,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [ALU_W-1:0] alu_op,
    output logic             ld_a,
    output logic             ld_b,
    output logic             b_inc,
    output logic             b_dec
);
    logic          rst_int;
    logic [AW-1:0] p_addr;
    logic [DW-1:0] p_wdata;
    logic          p_rd, p_wr;

    seq_rst_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_ext (rst_ext),
        .rst_int (rst_int)
    );

    seq_ctrl #(.AW(AW), .DW(DW)) i_ctrl (
        .clk       (clk),
        .rst       (rst_int),
        .mem_rdata (mem_rdata),
        .flag_gt   (flag_gt),
        .acc_in    (acc_in),
        .p_addr    (p_addr),
        .p_wdata   (p_wdata),
        .p_rd      (p_rd),
        .p_wr      (p_wr),
        .alu_op    (alu_op),
        .ld_a      (ld_a),
        .ld_b      (ld_b),
        .b_inc     (b_inc),
        .b_dec     (b_dec)
    );

    always_comb begin
        if (rst_int) begin
            mem_addr  = ldr_addr;
            mem_wdata = ldr_wdata;
            mem_wr    = ldr_wr;
            mem_rd    = 1'b0;
        end else begin
            mem_addr  = p_addr;
            mem_wdata = p_wdata;
            mem_wr    = p_wr;
            mem_rd    = p_rd;
        end
    end
endmodule

// File: tb/test_acc_seq_ctrl.sv
`timescale 1ns/1ps
module test_acc_seq_ctrl;
    logic        clk = 1'b0;
    logic        rst_ext = 1'b1;
    logic [7:0]  ldr_addr = '0;
    logic [15:0] ldr_wdata = '0;
    logic        ldr_wr = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        flag_gt = 1'b0;
    logic [15:0] acc_in = '0;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_rd, mem_wr;
    logic [4:0]  alu_op;
    logic        ld_a, ld_b, b_inc, b_dec;

    always #2.5 clk = ~clk;

    acc_seq_ctrl i_acc_seq_ctrl (
        .clk (clk), .rst_ext (rst_ext),
        .ldr_addr (ldr_addr), .ldr_wdata (ldr_wdata), .ldr_wr (ldr_wr),
        .mem_rdata (mem_rdata), .flag_gt (flag_gt), .acc_in (acc_in),
        .mem_addr (mem_addr), .mem_wdata (mem_wdata),
        .mem_rd (mem_rd), .mem_wr (mem_wr), .alu_op (alu_op),
        .ld_a (ld_a), .ld_b (ld_b), .b_inc (b_inc), .b_dec (b_dec)
    );

    logic [15:0] mem [256];
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_CTL = 2'd2;
    typedef struct packed {
        logic [1:0]  k;
        logic [7:0]  a;
        logic [15:0] d;
        logic [8:0]  c;
    } ev_t;

    ev_t   expq[$];
    string tagq[$];
    int    n_chk = 0, n_fail = 0;
    bit    done = 1'b0;
    bit    mon_en = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic ev_t mk(input logic [1:0] k, input logic [7:0] a, input logic [15:0] d, input logic [8:0] c);
        ev_t e;
        e.k = k; e.a = a; e.d = d; e.c = c;
        return e;
    endfunction

    task automatic push_rd(input logic [7:0] a, input string tag);
        expq.push_back(mk(K_RD, a, 16'h0, 9'h0)); tagq.push_back(tag);
    endtask
    task automatic push_wr(input logic [7:0] a, input logic [15:0] d, input string tag);
        expq.push_back(mk(K_WR, a, d, 9'h0)); tagq.push_back(tag);
    endtask
    task automatic push_ctl(input logic [4:0] op, input bit a, input bit b, input bit i, input bit d, input string tag);
        expq.push_back(mk(K_CTL, 8'h0, 16'h0, {op, a, b, i, d})); tagq.push_back(tag);
    endtask

    task automatic take(input ev_t got);
        ev_t e;
        string t;
        if (expq.size() == 0) begin
            chk(1'b0, "R9 unexpected activity", 40'(got), 40'h0);
        end else begin
            e = expq.pop_front();
            t = tagq.pop_front();
            chk(got == e, t, 40'(got), 40'(e));
        end
    endtask

    // monitor: samples at the falling edge
    always @(negedge clk) begin
        if (!mon_en) begin
            flag_gt <= 1'b0;
        end else begin
            if (mem_rd) begin
                take(mk(K_RD, mem_addr, 16'h0, 9'h0));
                if (mem_addr == 8'd20) flag_gt <= 1'b1;
            end
            if (mem_wr) take(mk(K_WR, mem_addr, mem_wdata, 9'h0));
            if (ld_a || ld_b || b_inc || b_dec || alu_op != 5'h0)
                take(mk(K_CTL, 8'h0, 16'h0, {alu_op, ld_a, ld_b, b_inc, b_dec}));
        end
    end

    function automatic logic [15:0] prog(input int i);
        case (i)
            0: return 16'h8030;              // index <- 80h
            1: return 16'h0017;              // load B immediate
            2: return 16'h55AF;
            3: return 16'h001D;
            4: return 16'h001B;
            5: return 16'h0020;
            6: return 16'h0034;
            7: return 16'h0031;
            8: return 16'h0033;
            9: return 16'h000C;
            10: return 16'h000D;
            11: return 16'h0340;             // branch +3, flag low
            12: return 16'h00FF;             // unassigned opcode
            13: return 16'h0441;             // call +4 -> 18
            14: return 16'h0007;             // halt
            18: return 16'h0032;
            19: return 16'h0034;
            20: return 16'h0240;             // branch +2, flag high -> 23
            23: return 16'h0042;             // return -> 14
            default: return 16'h0034;        // trap: store
        endcase
    endfunction

    task automatic expect_program(input logic [15:0] acc);
        push_rd(8'd0, "R3 first fetch at 0");
        push_rd(8'd1, "R3 fetch LDB");
        push_rd(8'd2, "R4 immediate read");
        push_ctl(5'h00, 0, 1, 0, 0, "R4 ld_b pass");
        push_rd(8'd3, "R3 fetch LAB");
        push_ctl(5'h01, 1, 0, 0, 0, "R5 LAB");
        push_rd(8'd4, "R3 fetch CNB");
        push_ctl(5'h0A, 0, 1, 0, 0, "R5 CNB");
        push_rd(8'd5, "R3 fetch FGO");
        push_ctl(5'h0B, 1, 1, 0, 0, "R5 FGO");
        push_rd(8'd6, "R3 fetch STA");
        push_wr(8'h80, acc, "R6 store at index");
        push_rd(8'd7, "R3 fetch INX");
        push_rd(8'd8, "R3 fetch LDA");
        push_rd(8'h81, "R6 load at incremented index");
        push_ctl(5'h00, 1, 0, 0, 0, "R6 ld_a pass");
        push_rd(8'd9, "R3 fetch INCB");
        push_ctl(5'h00, 0, 0, 1, 0, "R5 b_inc");
        push_rd(8'd10, "R3 fetch DECB");
        push_ctl(5'h00, 0, 0, 0, 1, "R5 b_dec");
        push_rd(8'd11, "R3 fetch BGT");
        push_rd(8'd12, "R7 branch not taken");
        push_rd(8'd13, "R9 unassigned opcode inert");
        push_rd(8'd18, "R8 call target");
        push_rd(8'd19, "R6 fetch after DEX");
        push_wr(8'h80, acc, "R6 store at decremented index");
        push_rd(8'd20, "R3 fetch BGT");
        push_rd(8'd23, "R7 branch taken");
        push_rd(8'd14, "R8 return to saved address");
    endtask

    task automatic run(input logic [15:0] acc);
        mon_en = 1'b0;
        rst_ext = 1'b1;
        acc_in = acc;
        @(negedge clk);
        chk(!mem_rd && !ld_a && !ld_b && !b_inc && !b_dec && alu_op == 5'h0, "R2 reset state",
            40'({mem_rd, ld_a, ld_b, b_inc, b_dec, alu_op}), 40'h0);
        for (int i = 0; i < 24; i++) begin
            ldr_addr = 8'(i);
            ldr_wdata = prog(i);
            ldr_wr = 1'b1;
            #1;
            chk(mem_wr && mem_addr == 8'(i) && mem_wdata == prog(i) && !mem_rd, "R2 loader owns bus",
                40'({mem_rd, mem_wr, mem_addr, mem_wdata}), 40'({1'b0, 1'b1, 8'(i), prog(i)}));
            @(negedge clk);
        end
        ldr_wr = 1'b0;
        ldr_addr = 8'hEE;
        rst_ext = 1'b0;
        @(negedge clk);
        chk(!mem_rd && mem_addr == 8'hEE, "R1 reset held one edge after release",
            40'({mem_rd, mem_addr}), 40'({1'b0, 8'hEE}));
        expect_program(acc);
        mon_en = 1'b1;
        for (int w = 0; w < 400; w++) begin
            if (expq.size() == 0) break;
            @(negedge clk);
        end
        repeat (30) @(negedge clk);
        chk(expq.size() == 0, "R9 all events seen, then halted", 40'(expq.size()), 40'h0);
        mon_en = 1'b0;
    endtask

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        end
    endtask

    initial begin
        run(16'hA5C3);
        run(16'h3C5A);
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            report();
            $finish;
        end
    end
endmodule